// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block is the address front end of an I2C target. It oversamples the SCL and SDA lines on the system clock and finds the START, repeated START and STOP conditions. After each START it collects the first byte and sorts it into one of several classes. The classes are: the device's own 7-bit address, the general call, the START byte, the prefix that opens a 10-bit address, other reserved codes, and foreign addresses. When the byte is meant for this device, the block pulls SDA low for the acknowledge clock.

The device address has two parts. The upper bits come from a build-time constant and the lower bits come from configuration pins. General-call response can be switched on or off with an input. A 10-bit address is accepted in two bytes. The read form of the prefix is accepted only after a 10-bit write selection has been made and no STOP has occurred since. Downstream logic sees a selection flag, the transfer direction, a general-call flag and a 10-bit flag. These flags stay valid until the next START or STOP. Data bytes after the address are handled elsewhere.

Top module: `i2c_tgt_addr_match`

## Requirements
- R1: The own address is the 7-bit value {FIXED_HI, addr_pins_i} (default FIXED_HI = 4'b1010). A first byte equal to this address followed by a direction bit in bit 0 (0 = write, 1 = read) is acknowledged, sets hit_o, and copies the direction bit to rd_o.
- R2: A first byte whose upper 7 bits match none of the accepted codes gets no acknowledge, and hit_o stays 0.
- R3: The byte 0x00 (address 0000000, write) is acknowledged with hit_o = 1, gcall_o = 1 and rd_o = 0 while gc_en_i = 1. While gc_en_i = 0 it is not acknowledged and gcall_o stays 0.
- R4: The START byte 0x01 is never acknowledged, whatever the value of gc_en_i.
- R5: Other addresses of the form 0000xxx or 1111xxx that are not defined codes (for example 0000011 or 1111100) are not acknowledged.
- R6: A first byte 11110 followed by TEN_ADDR[9:8] and a write bit is acknowledged without setting hit_o. If the next byte equals TEN_ADDR[7:0], it is acknowledged and sets hit_o and ten_o with rd_o = 0. A different second byte, or a prefix with other upper bits, is not acknowledged.
- R7: The read form of the prefix (same upper bits, bit 0 = 1) is acknowledged, with hit_o, ten_o and rd_o all set, only when a 10-bit write selection has been made since the last STOP.
- R8: The acknowledge holds SDA low for the whole ninth SCL high period. The block releases SDA on the SCL falling edge that ends that period, and it never starts pulling while SCL is high.
- R9: A repeated START clears hit_o, rd_o, gcall_o and ten_o, and the following byte is decoded as a fresh first byte.
- R10: A STOP clears all outputs and discards any 10-bit selection.
- R11: After reset sda_pull_o, hit_o, rd_o, gcall_o and ten_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_pins_i | input | PIN_W | Low bits of the own 7-bit address |
| gc_en_i | input | 1 | Enables response to the general call |
| sda_pull_o | output | 1 | 1 = drive SDA low (open drain) |
| hit_o | output | 1 | Transfer addressed to this device |
| rd_o | output | 1 | Direction of the addressed transfer, 1 = read |
| gcall_o | output | 1 | Selection was through the general call |
| ten_o | output | 1 | Selection was through a 10-bit address |

## Verification
One SCL falling edge does two jobs in the 10-bit write sequence. It ends the acknowledge of the prefix, releasing SDA, and it starts the collection of the second address byte. The bench sends the second byte straight after the prefix acknowledge with no idle gap. It then judges that the prefix acknowledge was released on time and that the second byte was assembled correctly, which shows up as its own acknowledge together with hit_o and ten_o. A repeated START arriving while a selection is still held is the second overlap. The bench checks that the old flags are gone before the new byte is judged.

// File: rtl/i2c_tam_pkg.sv
package i2c_tam_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR2, ST_WAIT, ST_ACK, ST_SEL, ST_SKIP
  } tam_state_e;

  typedef enum logic [2:0] {
    K_OWN, K_GCALL, K_STARTB, K_TEN, K_RSVD, K_OTHER
  } addr_kind_e;

  // Sort a 7-bit address (plus direction) into its class.
  function automatic addr_kind_e tam_classify(input logic [6:0] a,
                                              input logic [6:0] own,
                                              input logic       rw);
    if (a == own)                          return K_OWN;
    if (a == 7'd0)                         return rw ? K_STARTB : K_GCALL;
    if (a[6:2] == 5'b11110)                return K_TEN;
    if (a[6:3] == 4'h0 || a[6:3] == 4'hF)  return K_RSVD;
    return K_OTHER;
  endfunction

endpackage

// File: rtl/i2c_tam_sync.sv
module i2c_tam_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tam_shift.sv
module i2c_tam_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en_rise,
  input  logic         bit_i,
  output logic [W-1:0] byte_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      byte_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (en_rise && cnt <= LAST) begin
        byte_o <= {byte_o[W-2:0], bit_i};
        cnt    <= cnt + 1'b1;
        done_o <= (cnt == LAST);
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
  import i2c_tam_pkg::*;
#(
  parameter int             PIN_W    = 3,
  parameter logic [6-PIN_W:0] FIXED_HI = 4'b1010,
  parameter bit             TEN_EN   = 1'b1,
  parameter logic [9:0]     TEN_ADDR = 10'h2C6,
  parameter int             SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [PIN_W-1:0] addr_pins_i,
  input  logic             gc_en_i,
  output logic             sda_pull_o,
  output logic             hit_o,
  output logic             rd_o,
  output logic             gcall_o,
  output logic             ten_o
);
  // Named internal events, also observed by the bound checker.
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [7:0] rx_byte;
  logic       byte_done;
  logic       shift_clr, shift_en;
  logic [6:0] own7;
  tam_state_e st;
  addr_kind_e kind;

  logic dec_ack, dec_fin, dec_rd, dec_gc, dec_ten, dec_two, arm_nx;
  logic ack_q, fin_q, rd_q, gc_q, ten_q, two_q, armed;

  assign own7 = {FIXED_HI, addr_pins_i};

  i2c_tam_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign shift_clr = start_ev | (st == ST_ACK && scl_fall);
  assign shift_en  = scl_rise & (st == ST_ADDR || st == ST_ADDR2);

  i2c_tam_shift #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(shift_clr), .en_rise(shift_en),
    .bit_i(sda_s), .byte_o(rx_byte), .done_o(byte_done)
  );

  // Decision on a completed address byte.
  always_comb begin
    kind    = tam_classify(rx_byte[7:1], own7, rx_byte[0]);
    dec_ack = 1'b0; dec_fin = 1'b0; dec_rd = 1'b0;
    dec_gc  = 1'b0; dec_ten = 1'b0; dec_two = 1'b0;
    arm_nx  = armed;
    if (st == ST_ADDR) begin
      arm_nx = 1'b0;
      case (kind)
        K_OWN: begin
          dec_ack = 1'b1; dec_fin = 1'b1; dec_rd = rx_byte[0];
        end
        K_GCALL: begin
          dec_ack = gc_en_i; dec_fin = gc_en_i; dec_gc = gc_en_i;
        end
        K_TEN: begin
          if (TEN_EN && rx_byte[2:1] == TEN_ADDR[9:8]) begin
            if (!rx_byte[0]) begin
              dec_ack = 1'b1; dec_two = 1'b1;
            end else if (armed) begin
              dec_ack = 1'b1; dec_fin = 1'b1; dec_rd = 1'b1;
              dec_ten = 1'b1; arm_nx = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end else if (st == ST_ADDR2) begin
      if (rx_byte == TEN_ADDR[7:0]) begin
        dec_ack = 1'b1; dec_fin = 1'b1; dec_ten = 1'b1; arm_nx = 1'b1;
      end else begin
        arm_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      {sda_pull_o, hit_o, rd_o, gcall_o, ten_o} <= '0;
      {ack_q, fin_q, rd_q, gc_q, ten_q, two_q, armed} <= '0;
    end else if (stop_ev) begin
      st <= ST_IDLE;
      {sda_pull_o, hit_o, rd_o, gcall_o, ten_o} <= '0;
      armed <= 1'b0;
    end else if (start_ev) begin
      st <= ST_ADDR;
      {sda_pull_o, hit_o, rd_o, gcall_o, ten_o} <= '0;
    end else begin
      case (st)
        ST_ADDR, ST_ADDR2: if (byte_done) begin
          ack_q <= dec_ack; fin_q <= dec_fin; rd_q <= dec_rd;
          gc_q  <= dec_gc;  ten_q <= dec_ten; two_q <= dec_two;
          armed <= arm_nx;
          st    <= ST_WAIT;
        end
        ST_WAIT: if (scl_fall) begin
          if (ack_q) begin
            sda_pull_o <= 1'b1;
            st         <= ST_ACK;
            if (fin_q) begin
              hit_o <= 1'b1; rd_o <= rd_q; gcall_o <= gc_q; ten_o <= ten_q;
            end
          end else begin
            st <= ST_SKIP;
          end
        end
        ST_ACK: if (scl_fall) begin
          sda_pull_o <= 1'b0;
          st         <= two_q ? ST_ADDR2 : ST_SEL;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tam_chk.sv
module i2c_tam_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_fall,
  input logic start_ev,
  input logic stop_ev,
  input logic gc_en_i,
  input logic sda_pull_o,
  input logic hit_o,
  input logic rd_o,
  input logic gcall_o,
  input logic ten_o
);
  AST_PULL_BEGINS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s); // R8
  AST_PULL_ENDS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> ($past(scl_fall) || $past(stop_ev) || $past(start_ev))); // R8
  AST_HIT_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_o) |-> $rose(sda_pull_o)); // R1
  AST_GCALL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gcall_o) |-> $past(gc_en_i)); // R3
  AST_GCALL_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    gcall_o |-> (hit_o && !rd_o)); // R3
  AST_TEN_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ten_o |-> hit_o); // R6
  AST_RSTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (!hit_o && !gcall_o && !ten_o)); // R9
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!hit_o && !sda_pull_o)); // R10
endmodule

bind i2c_tgt_addr_match i2c_tam_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_ev(start_ev), .stop_ev(stop_ev), .gc_en_i(gc_en_i),
  .sda_pull_o(sda_pull_o), .hit_o(hit_o), .rd_o(rd_o),
  .gcall_o(gcall_o), .ten_o(ten_o)
);

// File: tb/sim_i2c_tgt_addr_match.sv
`timescale 1ns/1ps
module sim_i2c_tgt_addr_match;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] pins = 3'b101;
  logic gc_en = 1'b0;
  logic sda_pull, hit, rd, gcall, ten;
  logic sda_line;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  i2c_tgt_addr_match u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .addr_pins_i(pins), .gc_en_i(gc_en), .sda_pull_o(sda_pull),
    .hit_o(hit), .rd_o(rd), .gcall_o(gcall), .ten_o(ten)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wclk(Q); m_scl = 1'b1; wclk(Q);
    m_sda = 1'b0; wclk(Q); m_scl = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wclk(Q); m_scl = 1'b1; wclk(Q);
    m_sda = 1'b1; wclk(2*Q);
  endtask

  // Sends a byte MSB first; reports ack seen early/late in the 9th high and release.
  task automatic send_byte(input logic [7:0] b, output bit ack, output bit held, output bit rel);
    bit a1, a2;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wclk(Q); m_scl = 1'b1; wclk(2*Q); m_scl = 1'b0; wclk(Q);
    end
    m_sda = 1'b1; wclk(Q);
    m_scl = 1'b1; wclk(1);
    a1 = ~sda_line;
    wclk(2*Q-2);
    a2 = ~sda_line;
    wclk(1);
    m_scl = 1'b0; wclk(Q-1);
    rel = sda_line;
    wclk(1);
    ack = a1; held = a1 & a2;
  endtask

  task automatic t_reset;
    check(sda_pull == 0 && hit == 0 && rd == 0 && gcall == 0 && ten == 0,
          "R11 reset outputs", {sda_pull, hit, rd, gcall, ten}, 0);
  endtask

  task automatic t_own;
    bit a, h, r;
    pins = 3'b101;
    bus_start; send_byte(8'hAA, a, h, r);
    check(a, "R1 own write ack", a, 1);
    check(hit && !rd && !gcall && !ten, "R1 own write flags", {hit, rd, gcall, ten}, 4'b1000);
    check(h && r, "R8 ack held and released", {h, r}, 2'b11);
    bus_stop;
    check(!hit, "R10 stop clears hit", hit, 0);
    bus_start; send_byte(8'hAB, a, h, r);
    check(a && hit && rd, "R1 own read", {a, hit, rd}, 3'b111);
    bus_stop;
    pins = 3'b110;
    bus_start; send_byte(8'hAC, a, h, r);
    check(a && hit, "R1 pins change address", {a, hit}, 2'b11);
    bus_stop;
    bus_start; send_byte(8'hAA, a, h, r);
    check(!a && !hit, "R2 old address now foreign", {a, hit}, 0);
    bus_stop;
    pins = 3'b101;
  endtask

  task automatic t_foreign;
    bit a, h, r;
    bus_start; send_byte(8'h44, a, h, r);
    check(!a && !hit, "R2 foreign 0x22 write", {a, hit}, 0);
    bus_stop;
  endtask

  task automatic t_gcall;
    bit a, h, r;
    gc_en = 1'b1;
    bus_start; send_byte(8'h00, a, h, r);
    check(a && hit && gcall && !rd, "R3 gcall enabled", {a, hit, gcall, rd}, 4'b1110);
    bus_stop;
    gc_en = 1'b0;
    bus_start; send_byte(8'h00, a, h, r);
    check(!a && !hit && !gcall, "R3 gcall disabled", {a, hit, gcall}, 0);
    bus_stop;
  endtask

  task automatic t_startbyte;
    bit a, h, r;
    gc_en = 1'b1;
    bus_start; send_byte(8'h01, a, h, r);
    check(!a && !hit, "R4 start byte gc on", {a, hit}, 0);
    bus_stop;
    gc_en = 1'b0;
    bus_start; send_byte(8'h01, a, h, r);
    check(!a && !hit, "R4 start byte gc off", {a, hit}, 0);
    bus_stop;
  endtask

  task automatic t_reserved;
    bit a, h, r;
    bus_start; send_byte(8'h06, a, h, r);
    check(!a, "R5 reserved 0000011", a, 0);
    bus_stop;
    bus_start; send_byte(8'hF8, a, h, r);
    check(!a, "R5 reserved 1111100", a, 0);
    bus_stop;
  endtask

  task automatic t_ten;
    bit a, h, r;
    bus_start; send_byte(8'hF4, a, h, r);
    check(a && h && r && !hit, "R6 prefix ack no hit", {a, h, r, hit}, 4'b1110);
    send_byte(8'hC6, a, h, r);
    check(a && hit && ten && !rd, "R6 second byte match", {a, hit, ten, rd}, 4'b1110);
    bus_start; send_byte(8'hF5, a, h, r);
    check(a && hit && ten && rd, "R7 ten read after write", {a, hit, ten, rd}, 4'b1111);
    bus_stop;
    check(!hit && !ten, "R10 stop clears ten", {hit, ten}, 0);
    bus_start; send_byte(8'hF5, a, h, r);
    check(!a && !hit, "R7 ten read unarmed", {a, hit}, 0);
    bus_stop;
    bus_start; send_byte(8'hF4, a, h, r); send_byte(8'hC7, a, h, r);
    check(!a && !hit, "R6 second byte mismatch", {a, hit}, 0);
    bus_stop;
    bus_start; send_byte(8'hF2, a, h, r);
    check(!a, "R6 prefix wrong top bits", a, 0);
    bus_stop;
  endtask

  task automatic t_rstart;
    bit a, h, r;
    bus_start; send_byte(8'hAA, a, h, r);
    check(a && hit, "R9 selected before rstart", {a, hit}, 2'b11);
    bus_start;
    check(!hit && !rd, "R9 rstart clears", {hit, rd}, 0);
    send_byte(8'h44, a, h, r);
    check(!a && !hit, "R9 foreign after rstart", {a, hit}, 0);
    bus_start; send_byte(8'hAB, a, h, r);
    check(a && hit && rd, "R9 own read after rstart", {a, hit, rd}, 3'b111);
    bus_stop;
  endtask

  initial begin
    wclk(4); rst_n = 1'b1; wclk(4);
    t_reset;
    t_own;
    t_foreign;
    t_gcall;
    t_startbyte;
    t_reserved;
    t_ten;
    t_rstart;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule